// File: doc/BRIEF.md
# Instruction Length Decoder

This block takes a stream of variable-length machine instructions, one byte per cycle, and finds where each instruction starts and stops. Every byte is placed into one of six roles: prefix, opcode, operand-mode byte, index byte, displacement or immediate. The total length of an instruction is built up as its bytes arrive. It depends on how many prefixes there are, on the operand-mode field, and on the immediate size that a built-in opcode table gives.

Upstream logic offers bytes with `valid_i`. A byte is taken in any cycle in which `valid_i` and `ready_o` are both high. When the last byte of an instruction has been taken, the decoder raises `rec_vld_o` for one cycle in the following cycle. At the same time it presents a record with the length, prefix count, opcode, operand-mode byte, whether an index byte was present, and the displacement and immediate sizes. An instruction that reaches the hard length cap without completing produces an error record, and so does an instruction with a fifth prefix.

Top module: `ild_scan`

## Requirements
- R1: `ready_o` is high in every cycle from the second clock edge after reset is released. A byte is consumed only when `valid_i` and `ready_o` are both high. A cycle with `valid_i` low has no effect on decoding. After reset, `rec_vld_o` is low.
- R2: `rec_vld_o` is high for exactly one cycle for each instruction. That cycle is the one after the clock edge that consumed the instruction's final byte, and `rec_vld_o` is low at all other times.
- R3: The bytes 0xF0, 0xF2, 0xF3, 0x26, 0x2E, 0x36, 0x3E, 0x66 and 0x67 are prefixes when they appear before the opcode. `rec_pfx_o` reports how many were seen, up to 4.
- R4: When a prefix byte arrives after 4 prefixes already, the instruction ends at once with `rec_len_err_o`=1, `rec_len_o`=5 and `rec_pfx_o`=4. The next byte starts a new instruction.
- R5: The opcode byte 0x0F is an escape. The following byte is the opcode of the two-byte map, `rec_esc_o`=1, and `rec_opc_o` holds the second byte. For a one-byte opcode, `rec_esc_o`=0 and `rec_opc_o` holds the opcode byte.
- R6: The one-byte map is defined by ranges and single opcodes.
  - For opcodes 0x00-0x3F with low 3 bits of 0-3: an operand-mode byte and no immediate. Low bits of 4: a 1-byte immediate. Low bits of 5: a Z-sized immediate.
  - 0x80, 0x83 and 0xC6: an operand-mode byte and a 1-byte immediate. 0x81 and 0xC7: an operand-mode byte and a Z-sized immediate. 0x88-0x8B: an operand-mode byte only.
  - 0xB0-0xB7 and 0xEB: a 1-byte immediate. 0xB8-0xBF, 0xE8 and 0xE9: a Z-sized immediate. 0xC2: a 2-byte immediate.
  - Every other opcode is a single byte.
- R7: The two-byte map works as follows. 0x80-0x8F take a Z-sized immediate and no operand-mode byte. 0xAF, 0xB6 and 0xB7 take an operand-mode byte. 0xBA takes an operand-mode byte and a 1-byte immediate. 0xC7 takes an operand-mode byte and a Z-sized immediate. All others end at the second opcode byte.
- R8: Bits [7:6] of the operand-mode byte select the displacement. Codes 00 and 11 give none and code 01 gives 1 byte. Code 10 adds an index byte (`rec_sib_vld_o`=1) followed by a 4-byte displacement.
- R9: If a 0x67 prefix is present, mode code 10 takes a 2-byte displacement instead of 4 bytes. Mode code 01 is not affected.
- R10: A Z-sized immediate is 4 bytes, or 2 bytes if a 0x66 prefix is present. Fixed-size immediates are not affected.
- R11: `rec_scale_rsv_o` is 1 when bits [7:6] of the index byte are 11, and 0 in every other case.
- R12: An instruction may be up to 15 bytes long, and an instruction of exactly 15 bytes decodes normally. If the 15th byte arrives and the instruction is still incomplete, an error record is produced with `rec_len_o`=15 and `rec_len_err_o`=1, and the next byte starts a new instruction. On an error record, only the length, the prefix count and the error flag are defined.
- R13: On a record without an error, `rec_len_o` equals the sum of these terms: the prefix count, 1, `rec_esc_o`, `rec_modrm_vld_o`, `rec_sib_vld_o`, `rec_disp_o` and `rec_imm_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Instruction stream byte |
| valid_i | input | 1 | `byte_i` is valid |
| ready_o | output | 1 | Decoder accepts a byte |
| rec_vld_o | output | 1 | Record strobe, one cycle |
| rec_len_o | output | LEN_W (4) | Instruction length in bytes |
| rec_pfx_o | output | PFX_W (3) | Number of prefix bytes |
| rec_esc_o | output | 1 | Two-byte opcode map used |
| rec_opc_o | output | 8 | Opcode byte (second byte if escaped) |
| rec_modrm_vld_o | output | 1 | Operand-mode byte present |
| rec_modrm_o | output | 8 | Operand-mode byte |
| rec_sib_vld_o | output | 1 | Index byte present |
| rec_disp_o | output | 3 | Displacement length in bytes |
| rec_imm_o | output | 3 | Immediate length in bytes |
| rec_len_err_o | output | 1 | Prefix overflow or length cap hit |
| rec_scale_rsv_o | output | 1 | Index byte uses reserved scale code |

## Verification
The bench builds the decoder with its defaults: a 15-byte cap, 4 prefixes and 0x0F as the escape. With these values the longest legal form is 16 bytes: four prefixes, an escaped opcode, a mode-10 operand byte, an index byte, a 4-byte displacement and a 4-byte immediate. That brings the cap error within reach, with a following byte restarting cleanly, next to an exactly-15-byte instruction that must decode normally. The fifth-prefix error and both override prefixes are also driven, in directed form and through a long run of random bytes with random gaps in `valid_i`.

// File: rtl/ild_pkg.sv
package ild_pkg;

  typedef enum logic [2:0] {
    ST_PFX,
    ST_OPC,
    ST_MODRM,
    ST_SIB,
    ST_DISP,
    ST_IMM
  } ild_state_e;

  typedef enum logic [1:0] {
    IMM_NONE,
    IMM_B,
    IMM_W,
    IMM_Z
  } imm_kind_e;

endpackage

// File: rtl/ild_pfx_det.sv
module ild_pfx_det (
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output logic       osz_o,
  output logic       asz_o
);
  localparam int NUM_PFX = 9;
  localparam logic [7:0] PFX_TBL [NUM_PFX] = '{
    8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'h66, 8'h67
  };

  logic [NUM_PFX-1:0] match;

  for (genvar g = 0; g < NUM_PFX; g++) begin : g_cmp
    assign match[g] = (byte_i == PFX_TBL[g]);
  end

  assign hit_o = |match;
  assign osz_o = (byte_i == 8'h66);
  assign asz_o = (byte_i == 8'h67);
endmodule

// File: rtl/ild_opc_lut.sv
module ild_opc_lut
  import ild_pkg::*;
(
  input  logic       esc_i,
  input  logic [7:0] op_i,
  input  logic       osz_i,
  output logic       modrm_o,
  output logic [2:0] imm_len_o
);
  imm_kind_e kind;

  always_comb begin
    modrm_o = 1'b0;
    kind    = IMM_NONE;
    if (esc_i) begin
      case (op_i) inside
        [8'h80:8'h8F]:        kind = IMM_Z;
        8'hAF, 8'hB6, 8'hB7:  modrm_o = 1'b1;
        8'hBA:                begin modrm_o = 1'b1; kind = IMM_B; end
        8'hC7:                begin modrm_o = 1'b1; kind = IMM_Z; end
        default: ;
      endcase
    end else if (op_i[7:6] == 2'b00) begin
      case (op_i[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: modrm_o = 1'b1;
        3'd4:                   kind = IMM_B;
        3'd5:                   kind = IMM_Z;
        default: ;
      endcase
    end else begin
      case (op_i) inside
        8'h80, 8'h83, 8'hC6:  begin modrm_o = 1'b1; kind = IMM_B; end
        8'h81, 8'hC7:         begin modrm_o = 1'b1; kind = IMM_Z; end
        [8'h88:8'h8B]:        modrm_o = 1'b1;
        [8'hB0:8'hB7], 8'hEB: kind = IMM_B;
        [8'hB8:8'hBF]:        kind = IMM_Z;
        8'hE8, 8'hE9:         kind = IMM_Z;
        8'hC2:                kind = IMM_W;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (kind)
      IMM_B:   imm_len_o = 3'd1;
      IMM_W:   imm_len_o = 3'd2;
      IMM_Z:   imm_len_o = osz_i ? 3'd2 : 3'd4;
      default: imm_len_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/ild_seq.sv
module ild_seq
  import ild_pkg::*;
#(
  parameter int         MAX_LEN = 15,
  parameter int         MAX_PFX = 4,
  parameter logic [7:0] ESC_OPC = 8'h0F,
  parameter int         LEN_W   = 4,
  parameter int         PFX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             acc_i,
  input  logic             pfx_hit_i,
  input  logic             osz_hit_i,
  input  logic             asz_hit_i,
  input  logic             lut_modrm_i,
  input  logic [2:0]       lut_imm_i,
  output logic             lut_esc_o,
  output logic             osz_o,
  output logic             ready_o,
  output logic             rec_vld_o,
  output logic [LEN_W-1:0] rec_len_o,
  output logic [PFX_W-1:0] rec_pfx_o,
  output logic             rec_esc_o,
  output logic [7:0]       rec_opc_o,
  output logic             rec_modrm_vld_o,
  output logic [7:0]       rec_modrm_o,
  output logic             rec_sib_vld_o,
  output logic [2:0]       rec_disp_o,
  output logic [2:0]       rec_imm_o,
  output logic             rec_len_err_o,
  output logic             rec_scale_rsv_o
);
  ild_state_e       state_q, n_state;
  logic [LEN_W-1:0] len_q, n_len;
  logic [PFX_W-1:0] pfx_q, n_pfx;
  logic             esc_q, n_esc;
  logic [7:0]       opc_q, n_opc;
  logic             mv_q, n_mv;
  logic [7:0]       modrm_q, n_modrm;
  logic             sib_q, n_sib;
  logic [2:0]       disp_q, n_disp;
  logic [2:0]       imm_q, n_imm;
  logic [2:0]       rem_q, n_rem;
  logic             osz_q, n_osz;
  logic             asz_q, n_asz;
  logic             srsv_q, n_srsv;
  logic             take_opc, done, err, sib_nx, rdy_q;
  logic [2:0]       dl;

  assign lut_esc_o = (state_q == ST_OPC);
  assign osz_o     = osz_q;
  assign ready_o   = rdy_q;

  always_comb begin
    n_state  = state_q;
    n_len    = len_q + LEN_W'(1);
    n_pfx    = pfx_q;
    n_esc    = esc_q;
    n_opc    = opc_q;
    n_mv     = mv_q;
    n_modrm  = modrm_q;
    n_sib    = sib_q;
    n_disp   = disp_q;
    n_imm    = imm_q;
    n_rem    = rem_q;
    n_osz    = osz_q;
    n_asz    = asz_q;
    n_srsv   = srsv_q;
    take_opc = 1'b0;
    done     = 1'b0;
    err      = 1'b0;
    sib_nx   = 1'b0;
    dl       = 3'd0;
    unique case (state_q)
      ST_PFX: begin
        if (pfx_hit_i) begin
          if (pfx_q == PFX_W'(MAX_PFX)) begin
            done = 1'b1;
            err  = 1'b1;
          end else begin
            n_pfx = pfx_q + PFX_W'(1);
            n_osz = osz_q | osz_hit_i;
            n_asz = asz_q | asz_hit_i;
          end
        end else if (byte_i == ESC_OPC) begin
          n_esc   = 1'b1;
          n_state = ST_OPC;
        end else begin
          take_opc = 1'b1;
        end
      end
      ST_OPC: take_opc = 1'b1;
      ST_MODRM: begin
        n_mv    = 1'b1;
        n_modrm = byte_i;
        case (byte_i[7:6])
          2'b01: dl = 3'd1;
          2'b10: begin
            sib_nx = 1'b1;
            dl     = asz_q ? 3'd2 : 3'd4;
          end
          default: ;
        endcase
        n_sib  = sib_nx;
        n_disp = dl;
        if (sib_nx) begin
          n_state = ST_SIB;
        end else if (dl != 3'd0) begin
          n_state = ST_DISP;
          n_rem   = dl;
        end else if (imm_q != 3'd0) begin
          n_state = ST_IMM;
          n_rem   = imm_q;
        end else begin
          done = 1'b1;
        end
      end
      ST_SIB: begin
        n_srsv  = (byte_i[7:6] == 2'b11);
        n_state = ST_DISP;
        n_rem   = disp_q;
      end
      ST_DISP: begin
        if (rem_q == 3'd1) begin
          if (imm_q != 3'd0) begin
            n_state = ST_IMM;
            n_rem   = imm_q;
          end else begin
            done = 1'b1;
          end
        end else begin
          n_rem = rem_q - 3'd1;
        end
      end
      ST_IMM: begin
        if (rem_q == 3'd1) done = 1'b1;
        else               n_rem = rem_q - 3'd1;
      end
      default: n_state = ST_PFX;
    endcase

    if (take_opc) begin
      n_opc = byte_i;
      n_imm = lut_imm_i;
      if (lut_modrm_i) begin
        n_state = ST_MODRM;
      end else if (lut_imm_i != 3'd0) begin
        n_state = ST_IMM;
        n_rem   = lut_imm_i;
      end else begin
        done = 1'b1;
      end
    end

    // cap: the byte that reaches MAX_LEN must also close the instruction
    if (!done && n_len == LEN_W'(MAX_LEN)) begin
      done = 1'b1;
      err  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q           <= 1'b0;
      state_q         <= ST_PFX;
      len_q           <= '0;
      pfx_q           <= '0;
      esc_q           <= 1'b0;
      opc_q           <= '0;
      mv_q            <= 1'b0;
      modrm_q         <= '0;
      sib_q           <= 1'b0;
      disp_q          <= '0;
      imm_q           <= '0;
      rem_q           <= '0;
      osz_q           <= 1'b0;
      asz_q           <= 1'b0;
      srsv_q          <= 1'b0;
      rec_vld_o       <= 1'b0;
      rec_len_o       <= '0;
      rec_pfx_o       <= '0;
      rec_esc_o       <= 1'b0;
      rec_opc_o       <= '0;
      rec_modrm_vld_o <= 1'b0;
      rec_modrm_o     <= '0;
      rec_sib_vld_o   <= 1'b0;
      rec_disp_o      <= '0;
      rec_imm_o       <= '0;
      rec_len_err_o   <= 1'b0;
      rec_scale_rsv_o <= 1'b0;
    end else begin
      rdy_q     <= 1'b1;
      rec_vld_o <= acc_i && done;
      if (acc_i) begin
        if (done) begin
          rec_len_o       <= n_len;
          rec_pfx_o       <= n_pfx;
          rec_esc_o       <= n_esc;
          rec_opc_o       <= n_opc;
          rec_modrm_vld_o <= n_mv;
          rec_modrm_o     <= n_modrm;
          rec_sib_vld_o   <= n_sib;
          rec_disp_o      <= n_disp;
          rec_imm_o       <= n_imm;
          rec_len_err_o   <= err;
          rec_scale_rsv_o <= n_srsv;
          state_q         <= ST_PFX;
          len_q           <= '0;
          pfx_q           <= '0;
          esc_q           <= 1'b0;
          opc_q           <= '0;
          mv_q            <= 1'b0;
          modrm_q         <= '0;
          sib_q           <= 1'b0;
          disp_q          <= '0;
          imm_q           <= '0;
          rem_q           <= '0;
          osz_q           <= 1'b0;
          asz_q           <= 1'b0;
          srsv_q          <= 1'b0;
        end else begin
          state_q <= n_state;
          len_q   <= n_len;
          pfx_q   <= n_pfx;
          esc_q   <= n_esc;
          opc_q   <= n_opc;
          mv_q    <= n_mv;
          modrm_q <= n_modrm;
          sib_q   <= n_sib;
          disp_q  <= n_disp;
          imm_q   <= n_imm;
          rem_q   <= n_rem;
          osz_q   <= n_osz;
          asz_q   <= n_asz;
          srsv_q  <= n_srsv;
        end
      end
    end
  end

  logic [5:0] fld_sum;
  assign fld_sum = 6'(rec_pfx_o) + 6'd1 + 6'(rec_esc_o) + 6'(rec_modrm_vld_o)
                 + 6'(rec_sib_vld_o) + 6'(rec_disp_o) + 6'(rec_imm_o);

  // R1
  rdy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ready_o);
  // R2
  rec_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |-> $past(acc_i));
  // R12
  len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |-> (rec_len_o >= LEN_W'(1) && rec_len_o <= LEN_W'(MAX_LEN)));
  // R3
  pfx_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |-> rec_pfx_o <= PFX_W'(MAX_PFX));
  // R8
  sib_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_vld_o && rec_sib_vld_o) |-> (rec_modrm_vld_o && rec_modrm_o[7:6] == 2'b10));
  // R13
  len_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_vld_o && !rec_len_err_o) |-> fld_sum == 6'(rec_len_o));
endmodule

// File: rtl/ild_scan.sv
module ild_scan #(
  parameter int         MAX_LEN = 15,
  parameter int         MAX_PFX = 4,
  parameter logic [7:0] ESC_OPC = 8'h0F,
  localparam int        LEN_W   = $clog2(MAX_LEN + 1),
  localparam int        PFX_W   = $clog2(MAX_PFX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             rec_vld_o,
  output logic [LEN_W-1:0] rec_len_o,
  output logic [PFX_W-1:0] rec_pfx_o,
  output logic             rec_esc_o,
  output logic [7:0]       rec_opc_o,
  output logic             rec_modrm_vld_o,
  output logic [7:0]       rec_modrm_o,
  output logic             rec_sib_vld_o,
  output logic [2:0]       rec_disp_o,
  output logic [2:0]       rec_imm_o,
  output logic             rec_len_err_o,
  output logic             rec_scale_rsv_o
);
  logic       acc, pfx_hit, osz_hit, asz_hit;
  logic       lut_esc, lut_osz, lut_modrm;
  logic [2:0] lut_imm;

  assign acc = valid_i && ready_o;

  ild_pfx_det i_pfx (
    .byte_i (byte_i),
    .hit_o  (pfx_hit),
    .osz_o  (osz_hit),
    .asz_o  (asz_hit)
  );

  ild_opc_lut i_lut (
    .esc_i     (lut_esc),
    .op_i      (byte_i),
    .osz_i     (lut_osz),
    .modrm_o   (lut_modrm),
    .imm_len_o (lut_imm)
  );

  ild_seq #(
    .MAX_LEN (MAX_LEN),
    .MAX_PFX (MAX_PFX),
    .ESC_OPC (ESC_OPC),
    .LEN_W   (LEN_W),
    .PFX_W   (PFX_W)
  ) i_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .byte_i          (byte_i),
    .acc_i           (acc),
    .pfx_hit_i       (pfx_hit),
    .osz_hit_i       (osz_hit),
    .asz_hit_i       (asz_hit),
    .lut_modrm_i     (lut_modrm),
    .lut_imm_i       (lut_imm),
    .lut_esc_o       (lut_esc),
    .osz_o           (lut_osz),
    .ready_o         (ready_o),
    .rec_vld_o       (rec_vld_o),
    .rec_len_o       (rec_len_o),
    .rec_pfx_o       (rec_pfx_o),
    .rec_esc_o       (rec_esc_o),
    .rec_opc_o       (rec_opc_o),
    .rec_modrm_vld_o (rec_modrm_vld_o),
    .rec_modrm_o     (rec_modrm_o),
    .rec_sib_vld_o   (rec_sib_vld_o),
    .rec_disp_o      (rec_disp_o),
    .rec_imm_o       (rec_imm_o),
    .rec_len_err_o   (rec_len_err_o),
    .rec_scale_rsv_o (rec_scale_rsv_o)
  );
endmodule

// File: tb/test_ild_scan.sv
module test_ild_scan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       valid = 1'b0;
  logic       ready_o, rec_vld_o, rec_esc_o, rec_modrm_vld_o, rec_sib_vld_o;
  logic       rec_len_err_o, rec_scale_rsv_o;
  logic [3:0] rec_len_o;
  logic [2:0] rec_pfx_o, rec_disp_o, rec_imm_o;
  logic [7:0] rec_opc_o, rec_modrm_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ild_scan i_ild_scan (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_in), .valid_i(valid),
    .ready_o(ready_o), .rec_vld_o(rec_vld_o), .rec_len_o(rec_len_o),
    .rec_pfx_o(rec_pfx_o), .rec_esc_o(rec_esc_o), .rec_opc_o(rec_opc_o),
    .rec_modrm_vld_o(rec_modrm_vld_o), .rec_modrm_o(rec_modrm_o),
    .rec_sib_vld_o(rec_sib_vld_o), .rec_disp_o(rec_disp_o), .rec_imm_o(rec_imm_o),
    .rec_len_err_o(rec_len_err_o), .rec_scale_rsv_o(rec_scale_rsv_o)
  );

  // reference model state
  logic [7:0] cur[$];
  bit pend = 0;
  int e_len, e_pfx, e_esc, e_opc, e_mv, e_modrm, e_sib, e_disp, e_imm, e_err, e_srsv;
  bit m_done;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_pfx(input logic [7:0] b);
    return b inside {8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'h66, 8'h67};
  endfunction

  // opcode table as stated in R6/R7/R10
  task automatic lookup(input bit esc, input logic [7:0] op, input bit osz,
                        output int mr, output int imm);
    int z;
    z = osz ? 2 : 4;
    mr = 0; imm = 0;
    if (esc) begin
      if (op >= 8'h80 && op <= 8'h8F) imm = z;
      else if (op == 8'hAF || op == 8'hB6 || op == 8'hB7) mr = 1;
      else if (op == 8'hBA) begin mr = 1; imm = 1; end
      else if (op == 8'hC7) begin mr = 1; imm = z; end
    end else if (op < 8'h40) begin
      if (op % 8 < 4) mr = 1;
      else if (op % 8 == 4) imm = 1;
      else if (op % 8 == 5) imm = z;
    end else if (op == 8'h80 || op == 8'h83 || op == 8'hC6) begin mr = 1; imm = 1; end
    else if (op == 8'h81 || op == 8'hC7) begin mr = 1; imm = z; end
    else if (op >= 8'h88 && op <= 8'h8B) mr = 1;
    else if ((op >= 8'hB0 && op <= 8'hB7) || op == 8'hEB) imm = 1;
    else if ((op >= 8'hB8 && op <= 8'hBF) || op == 8'hE8 || op == 8'hE9) imm = z;
    else if (op == 8'hC2) imm = 2;
  endtask

  // parse the bytes gathered so far from scratch
  task automatic model_eval();
    int i, n, need, mr, imm, m;
    bit osz, asz;
    logic [7:0] op;
    i = 0; n = cur.size(); m_done = 0;
    osz = 0; asz = 0;
    e_pfx = 0; e_esc = 0; e_opc = 0; e_mv = 0; e_modrm = 0; e_sib = 0;
    e_disp = 0; e_imm = 0; e_err = 0; e_srsv = 0;
    while (i < n && is_pfx(cur[i])) begin
      if (e_pfx == 4) begin
        m_done = 1; e_err = 1; e_len = i + 1;
        return;
      end
      e_pfx++;
      if (cur[i] == 8'h66) osz = 1;
      if (cur[i] == 8'h67) asz = 1;
      i++;
    end
    if (i == n) begin if (n == 15) begin m_done = 1; e_err = 1; e_len = 15; end return; end
    op = cur[i]; i++;
    if (op == 8'h0F) begin
      if (i == n) begin if (n == 15) begin m_done = 1; e_err = 1; e_len = 15; end return; end
      e_esc = 1; op = cur[i]; i++;
    end
    e_opc = op;
    lookup(e_esc == 1, op, osz, mr, imm);
    e_imm = imm;
    if (mr == 1) begin
      if (i == n) begin if (n == 15) begin m_done = 1; e_err = 1; e_len = 15; end return; end
      m = cur[i]; i++;
      e_mv = 1; e_modrm = m;
      if (m / 64 == 1) e_disp = 1;
      if (m / 64 == 2) begin e_sib = 1; e_disp = asz ? 2 : 4; end
      if (e_sib == 1) begin
        if (i == n) begin if (n == 15) begin m_done = 1; e_err = 1; e_len = 15; end return; end
        e_srsv = (cur[i][7:6] == 2'b11);
      end
    end
    need = i + e_sib + e_disp + e_imm;
    if (n == need) begin
      m_done = 1; e_len = n;
    end else if (n == 15) begin
      m_done = 1; e_err = 1; e_len = 15;
    end
  endtask

  task automatic check_out();
    chk("R2", "rec_vld", int'(rec_vld_o), int'(pend));
    if (pend && rec_vld_o) begin
      chk("R12 R13", "len", int'(rec_len_o), e_len);
      chk("R4 R12", "len_err", int'(rec_len_err_o), e_err);
      chk("R3", "pfx", int'(rec_pfx_o), e_pfx);
      if (e_err == 0) begin
        chk("R5", "esc", int'(rec_esc_o), e_esc);
        chk("R5", "opc", int'(rec_opc_o), e_opc);
        chk("R6 R7", "modrm_vld", int'(rec_modrm_vld_o), e_mv);
        if (e_mv == 1) chk("R8", "modrm", int'(rec_modrm_o), e_modrm);
        chk("R8", "sib_vld", int'(rec_sib_vld_o), e_sib);
        chk("R8 R9", "disp", int'(rec_disp_o), e_disp);
        chk("R6 R7 R10", "imm", int'(rec_imm_o), e_imm);
        chk("R11", "scale_rsv", int'(rec_scale_rsv_o), e_srsv);
      end
    end
  endtask

  task automatic push(input logic [7:0] b, input bit v);
    @(negedge clk);
    check_out();
    byte_in = b;
    valid = v;
    pend = 0;
    // R1: consumption only with valid and ready
    if (v && ready_o) begin
      cur.push_back(b);
      model_eval();
      if (m_done) begin
        pend = 1;
        cur.delete();
      end
    end
  endtask

  task automatic ins(input int n, input logic [119:0] v);
    for (int k = 0; k < n; k++) begin
      if ($urandom_range(0, 3) == 0) push(8'h00, 0);
      push(v[8*(n-1-k) +: 8], 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "ready after reset", int'(ready_o), 1);
    chk("R1", "rec_vld after reset", int'(rec_vld_o), 0);

    ins(1, 120'h90);
    ins(5, 120'h05_11_22_33_44);
    ins(4, 120'h66_05_11_22);                 // R10
    ins(2, 120'h01_C3);
    ins(3, 120'h01_45_08);                    // R8 mode 01
    ins(7, 120'h01_84_24_11_22_33_44);        // R8 mode 10
    ins(6, 120'h67_01_84_24_11_22);           // R9
    ins(4, 120'h67_01_45_08);                 // R9 mode 01 unchanged
    ins(6, 120'h81_C0_01_02_03_04);
    ins(6, 120'h0F_85_01_02_03_04);           // R5 R7
    ins(5, 120'h66_0F_85_01_02);              // R10 two-byte
    ins(3, 120'h0F_AF_C0);
    ins(4, 120'h0F_BA_E0_05);
    ins(2, 120'h0F_31);
    ins(3, 120'h83_C0_7F);
    ins(2, 120'hB0_12);
    ins(5, 120'hB8_01_02_03_04);
    ins(3, 120'hC2_10_00);                    // R10 fixed imm2 under 0x66 below
    ins(4, 120'h66_C2_10_00);
    ins(1, 120'hC3);
    ins(2, 120'hEB_FE);
    ins(4, 120'h66_F3_26_90);
    ins(5, 120'hF0_F2_F3_2E_90);              // R3 four prefixes
    ins(6, 120'h26_2E_36_3E_66_90);           // R4 fifth prefix, then restart
    ins(15, 120'hF0_F2_F3_26_81_84_24_11_22_33_44_01_02_03_04); // R12 exactly 15
    ins(15, 120'hF0_F2_F3_26_0F_C7_84_24_11_22_33_44_01_02_03); // R12 cap
    ins(1, 120'h90);                          // R12 restart after cap
    ins(7, 120'h01_84_E4_11_22_33_44);        // R11

    for (int k = 0; k < 4000; k++)
      push(8'($urandom_range(0, 255)), $urandom_range(0, 9) != 0);
    for (int k = 0; k < 20; k++) push(8'h90, 1);
    for (int k = 0; k < 3; k++) push(8'h00, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule